// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a physical page address using a small set of programmable block-mapping entries. It holds two sets of entries: one consulted for instruction fetches and one for every other access. Each entry is an upper word and a lower word. The upper word gives the address tag, a block-length field and two privilege-valid bits. The lower word gives the physical base and the access rights. The length field sets how many effective address bits are left out of the compare and are passed straight through to the physical address, so one entry can cover a range of block sizes starting at 128 KiB.

A lookup is strobed with `req_valid` and its result is registered one cycle later. A result is either a hit with a page-aligned physical address and read/write permission, or a miss. A miss tells a downstream page-table walker to take over, and the faulting address is captured in `fault_addr`. When translation is switched off for the access in hand, the address passes through page-aligned with full permission. Entries are loaded through a one-word write port. A write applies at the next clock edge, so a lookup strobed in the same cycle as a write still sees the old contents.

Top module: `bxt_unit`

## Requirements
- R1: A lookup with `req_fetch`=1 is matched against the instruction set. Any other lookup is matched against the data set. The write port selects the instruction set when `cfg_iset`=1, the entry with `cfg_idx`, and the lower word when `cfg_lower`=1 (upper word when 0).
- R2: An entry can match only if effective address bits 31:28 equal upper-word bits 31:28.
- R3: The block mask is upper-word bits 12:2 placed at address bits 27:17. Effective bits 27:17 with the masked positions cleared must equal upper-word bits 27:17. The masked effective bits are ORed into physical bits 27:17.
- R4: A supervisor lookup (`req_user`=0) needs upper-word bit 1 set. A user lookup (`req_user`=1) needs upper-word bit 0 set.
- R5: On a hit, the physical address is lower-word bits 31:28, then bits 27:17 as given in R3 ORed with lower-word bits 27:17, then effective bits 16:12, then twelve zero bits.
- R6: Permission comes from lower-word bits 1:0. If bit 1 is set, both read and write are allowed. The value 01 allows read only. The value 00 allows neither.
- R7: When several entries match, the one with the lowest index gives the result.
- R8: A translated lookup with no qualifying entry gives `rsp_miss`=1, `rsp_hit`=0, zero address and no permission, and loads `fault_addr` with the effective address. Any other result leaves `fault_addr` unchanged.
- R9: Translation is bypassed when a fetch occurs with `itrans_on`=0, or whenever `dtrans_on`=0. A bypassed result gives `rsp_bypass`=1, `rsp_hit`=1, the effective address with bits 11:0 cleared, and read and write allowed.
- R10: Each result appears on the cycle after its `req_valid` strobe, marked by a one-cycle `rsp_valid`. A register write is visible to lookups strobed from the next cycle on, and not to a lookup strobed in the same cycle.
- R11: Reset clears all entries, `rsp_valid`, `rsp_hit` and `fault_addr`. After reset, every translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_iset | input | 1 | 1 selects the instruction set, 0 the data set |
| cfg_idx | input | IDX_W | Entry index |
| cfg_lower | input | 1 | 1 selects the lower word, 0 the upper word |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup strobe |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| itrans_on | input | 1 | Instruction translation enabled |
| dtrans_on | input | 1 | Data translation enabled |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_hit | output | 1 | Translation hit or bypass |
| rsp_miss | output | 1 | No entry qualified |
| rsp_bypass | output | 1 | Result came from the bypass path |
| rsp_pa | output | 32 | Page-aligned physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| fault_addr | output | 32 | Effective address of the last miss |

## Verification
The same effective address is sent as a fetch and as a data access, with different contents in the two sets, so a result from the wrong set shows up as a wrong base. Addresses that differ only in the top nibble, or only in unmasked middle bits, separate the tag compare from the mask compare. An address inside a 2 MiB block separates the masked pass-through bits from the lower-word OR. Each address is tried under both privilege levels and with all access-right codes, to tell the valid-bit selection apart from the permission decode. Overlapping entries, an entry invalidated between lookups, and a write in the same cycle as a lookup show the index priority and the one-cycle write latency. The bypass cases turn off each enable in turn.

// File: rtl/bxt_pkg.sv
package bxt_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 12;
  // tag nibble, block-index field and length field positions
  localparam int TAG_HI = 31;
  localparam int TAG_LO = 28;
  localparam int BLK_HI = 27;
  localparam int BLK_LO = 17;
  localparam int BLK_W  = BLK_HI - BLK_LO + 1;
  localparam int LEN_HI = 12;
  localparam int LEN_LO = 2;
  localparam int OFS_HI = 16;
  localparam int OFS_LO = 12;
  localparam int VS_BIT = 1;  // supervisor valid
  localparam int VU_BIT = 0;  // user valid
  localparam int PR_RW  = 1;  // read/write grant
  localparam int PR_RO  = 0;  // read grant

  typedef logic [ADDR_W-1:0] word_t;

  typedef struct packed {
    logic  hit;
    logic  rd;
    logic  wr;
    word_t pa;
  } xl_res_t;
endpackage

// File: rtl/bxt_regbank.sv
module bxt_regbank
  import bxt_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic                        iset,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        lower,
  input  word_t                       wdata,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0] i_up,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0] i_lo,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0] d_up,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0] d_lo
);
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic sel_e;
    logic en_iu, en_il, en_du, en_dl;

    always_comb begin
      sel_e = we && (idx == IDX_W'(e));
      en_iu = sel_e &&  iset && !lower;
      en_il = sel_e &&  iset &&  lower;
      en_du = sel_e && !iset && !lower;
      en_dl = sel_e && !iset &&  lower;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        i_up[e] <= '0;
        i_lo[e] <= '0;
        d_up[e] <= '0;
        d_lo[e] <= '0;
      end else begin
        if (en_iu) i_up[e] <= wdata;
        if (en_il) i_lo[e] <= wdata;
        if (en_du) d_up[e] <= wdata;
        if (en_dl) d_lo[e] <= wdata;
      end
    end
  end
endmodule

// File: rtl/bxt_match.sv
module bxt_match
  import bxt_pkg::*;
(
  input  word_t upper,
  input  word_t lower,
  input  word_t ea,
  input  logic  user,
  output xl_res_t res
);
  logic [BLK_W-1:0] len_mask;
  logic             tag_eq;
  logic             blk_eq;
  logic             priv_ok;

  always_comb begin
    len_mask = upper[LEN_HI:LEN_LO];
    tag_eq   = (ea[TAG_HI:TAG_LO] == upper[TAG_HI:TAG_LO]);
    blk_eq   = ((ea[BLK_HI:BLK_LO] & ~len_mask) == upper[BLK_HI:BLK_LO]);
    priv_ok  = user ? upper[VU_BIT] : upper[VS_BIT];

    res.hit = tag_eq && blk_eq && priv_ok;
    res.rd  = lower[PR_RW] | lower[PR_RO];
    res.wr  = lower[PR_RW];
    res.pa  = {lower[TAG_HI:TAG_LO],
               (ea[BLK_HI:BLK_LO] & len_mask) | lower[BLK_HI:BLK_LO],
               ea[OFS_HI:OFS_LO],
               {PAGE_BITS{1'b0}}};
  end
endmodule

// File: rtl/bxt_select.sv
module bxt_select
  import bxt_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  xl_res_t [NUM_ENTRIES-1:0] cand,
  output xl_res_t                   pick
);
  // scan from the top so the lowest index is applied last and wins
  always_comb begin
    pick = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (cand[i].hit) pick = cand[i];
    end
  end
endmodule

// File: rtl/bxt_unit.sv
module bxt_unit
  import bxt_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_iset,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_lower,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [31:0]       req_ea,
  input  logic              req_fetch,
  input  logic              req_user,
  input  logic              itrans_on,
  input  logic              dtrans_on,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_bypass,
  output logic [31:0]       rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic [31:0]       fault_addr
);
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] i_up, i_lo, d_up, d_lo;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] s_up, s_lo;
  xl_res_t [NUM_ENTRIES-1:0]          cand;
  xl_res_t                            pick;

  bxt_regbank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .iset  (cfg_iset),
    .idx   (cfg_idx),
    .lower (cfg_lower),
    .wdata (cfg_wdata),
    .i_up  (i_up),
    .i_lo  (i_lo),
    .d_up  (d_up),
    .d_lo  (d_lo)
  );

  always_comb begin
    s_up = req_fetch ? i_up : d_up;
    s_lo = req_fetch ? i_lo : d_lo;
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    bxt_match u_match (
      .upper (s_up[e]),
      .lower (s_lo[e]),
      .ea    (req_ea),
      .user  (req_user),
      .res   (cand[e])
    );
  end

  bxt_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_sel (
    .cand (cand),
    .pick (pick)
  );

  // next-state
  logic  bypass_c;
  logic  nx_hit, nx_miss, nx_rd, nx_wr;
  word_t nx_pa;
  logic  rsp_en;
  logic  fault_en;

  always_comb begin
    bypass_c = (req_fetch && !itrans_on) || !dtrans_on;
    if (bypass_c) begin
      nx_hit  = 1'b1;
      nx_miss = 1'b0;
      nx_rd   = 1'b1;
      nx_wr   = 1'b1;
      nx_pa   = {req_ea[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    end else if (pick.hit) begin
      nx_hit  = 1'b1;
      nx_miss = 1'b0;
      nx_rd   = pick.rd;
      nx_wr   = pick.wr;
      nx_pa   = pick.pa;
    end else begin
      nx_hit  = 1'b0;
      nx_miss = 1'b1;
      nx_rd   = 1'b0;
      nx_wr   = 1'b0;
      nx_pa   = '0;
    end
    rsp_en   = req_valid;
    fault_en = req_valid && nx_miss;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_bypass <= 1'b0;
      rsp_pa     <= '0;
      rsp_rd     <= 1'b0;
      rsp_wr     <= 1'b0;
    end else if (rsp_en) begin
      rsp_hit    <= nx_hit;
      rsp_miss   <= nx_miss;
      rsp_bypass <= bypass_c;
      rsp_pa     <= nx_pa;
      rsp_rd     <= nx_rd;
      rsp_wr     <= nx_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr <= '0;
    end else if (fault_en) begin
      fault_addr <= req_ea;
    end
  end
endmodule

// File: rtl/bxt_unit_chk.sv
module bxt_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_miss,
  input logic        rsp_bypass,
  input logic [31:0] rsp_pa,
  input logic        rsp_rd,
  input logic        rsp_wr,
  input logic [31:0] fault_addr
);
  assert_strobe_to_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_resp_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_hit_xor_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));
  assert_miss_no_rights_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (!rsp_rd && !rsp_wr && rsp_pa == 32'h0));
  assert_fault_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (fault_addr == $past(req_ea)));
  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_miss) |-> $stable(fault_addr));
  assert_write_implies_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!rsp_wr || rsp_rd));
  assert_page_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_pa[11:0] == 12'h000));
  assert_bypass_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bypass) |-> (rsp_hit && rsp_rd && rsp_wr));
endmodule

bind bxt_unit bxt_unit_chk chk_i (.*);

// File: tb/bxt_unit_tb_top.sv
module bxt_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_we, cfg_iset, cfg_lower;
  logic [1:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_fetch, req_user;
  logic [31:0] req_ea;
  logic        itrans_on, dtrans_on;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_bypass, rsp_rd, rsp_wr;
  logic [31:0] rsp_pa, fault_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  bxt_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_iset(cfg_iset), .cfg_idx(cfg_idx),
    .cfg_lower(cfg_lower), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ea(req_ea), .req_fetch(req_fetch),
    .req_user(req_user), .itrans_on(itrans_on), .dtrans_on(dtrans_on),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_bypass(rsp_bypass), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd),
    .rsp_wr(rsp_wr), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // all tasks start and end on a falling edge
  task automatic wr_reg(input logic iset, input logic [1:0] idx,
                        input logic low, input logic [31:0] d);
    cfg_we = 1'b1; cfg_iset = iset; cfg_idx = idx; cfg_lower = low;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] ea, input logic f, input logic u);
    req_valid = 1'b1; req_ea = ea; req_fetch = f; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R10 rsp_valid after strobe", {31'b0, rsp_valid}, 32'h1);
  endtask

  // hit result: pa, rd, wr
  task automatic exp_hit(input string tag, input logic [31:0] pa,
                         input logic rd, input logic wr);
    chk_eq({tag, " hit"}, {31'b0, rsp_hit}, 32'h1);
    chk_eq({tag, " pa"},  rsp_pa, pa);
    chk_eq({tag, " rd/wr"}, {30'b0, rsp_rd, rsp_wr}, {30'b0, rd, wr});
  endtask

  task automatic exp_miss(input string tag, input logic [31:0] ea);
    chk_eq({tag, " miss"}, {30'b0, rsp_hit, rsp_miss}, 32'h1);
    chk_eq({tag, " fault"}, fault_addr, ea);
  endtask

  task automatic t_reset;
    chk_eq("R11 rsp_valid at reset", {31'b0, rsp_valid}, 32'h0);
    chk_eq("R11 rsp_hit at reset", {31'b0, rsp_hit}, 32'h0);
    chk_eq("R11 fault_addr at reset", fault_addr, 32'h0);
    look(32'h1234_5678, 1'b0, 1'b0);
    exp_miss("R11 empty entries", 32'h1234_5678);
    @(negedge clk);
    chk_eq("R10 rsp_valid one-shot", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_bank;
    wr_reg(1'b0, 2'd0, 1'b0, 32'h1234_0002);
    wr_reg(1'b0, 2'd0, 1'b1, 32'h8000_0002);
    wr_reg(1'b1, 2'd0, 1'b0, 32'h1234_0002);
    wr_reg(1'b1, 2'd0, 1'b1, 32'h4000_0001);
    look(32'h1234_5678, 1'b0, 1'b0);
    exp_hit("R1 R5 data set", 32'h8000_5000, 1'b1, 1'b1);
    look(32'h1234_5678, 1'b1, 1'b0);
    exp_hit("R1 R6 instr set", 32'h4000_5000, 1'b1, 1'b0);
    chk_eq("R8 fault kept on hit", fault_addr, 32'h1234_5678);
  endtask

  task automatic t_tag;
    look(32'h2234_5678, 1'b0, 1'b0);
    exp_miss("R2 tag nibble differs", 32'h2234_5678);
    look(32'h1236_5678, 1'b0, 1'b0);
    exp_miss("R3 unmasked block bit differs", 32'h1236_5678);
  endtask

  task automatic t_priv;
    look(32'h1234_5678, 1'b0, 1'b1);
    exp_miss("R4 user without user valid", 32'h1234_5678);
    wr_reg(1'b0, 2'd0, 1'b0, 32'h1234_0001);
    look(32'h1234_A000, 1'b0, 1'b1);
    exp_hit("R4 user with user valid", 32'h8000_A000, 1'b1, 1'b1);
    look(32'h1234_A000, 1'b0, 1'b0);
    exp_miss("R4 supervisor without sup valid", 32'h1234_A000);
  endtask

  task automatic t_mask;
    wr_reg(1'b0, 2'd1, 1'b0, 32'h3000_003E);
    wr_reg(1'b0, 2'd1, 1'b1, 32'hA080_0002);
    look(32'h301A_B123, 1'b0, 1'b0);
    exp_hit("R3 R5 masked pass-through", 32'hA09A_B000, 1'b1, 1'b1);
    look(32'h3020_0000, 1'b0, 1'b0);
    exp_miss("R3 bit above mask", 32'h3020_0000);
  endtask

  task automatic t_prot;
    wr_reg(1'b0, 2'd1, 1'b1, 32'hA080_0000);
    look(32'h301A_B123, 1'b0, 1'b0);
    exp_hit("R6 code 00", 32'hA09A_B000, 1'b0, 1'b0);
    wr_reg(1'b0, 2'd1, 1'b1, 32'hA080_0001);
    look(32'h301A_B123, 1'b0, 1'b0);
    exp_hit("R6 code 01", 32'hA09A_B000, 1'b1, 1'b0);
    wr_reg(1'b0, 2'd1, 1'b1, 32'hA080_0003);
    look(32'h301A_B123, 1'b0, 1'b0);
    exp_hit("R6 code 11", 32'hA09A_B000, 1'b1, 1'b1);
  endtask

  task automatic t_prio;
    wr_reg(1'b0, 2'd2, 1'b0, 32'h5000_0002);
    wr_reg(1'b0, 2'd2, 1'b1, 32'h6000_0001);
    wr_reg(1'b0, 2'd3, 1'b0, 32'h5000_0002);
    wr_reg(1'b0, 2'd3, 1'b1, 32'h7000_0002);
    look(32'h5000_3000, 1'b0, 1'b0);
    exp_hit("R7 lowest index wins", 32'h6000_3000, 1'b1, 1'b0);
    wr_reg(1'b0, 2'd2, 1'b0, 32'h0000_0000);
    look(32'h5000_3000, 1'b0, 1'b0);
    exp_hit("R7 next entry after invalidate", 32'h7000_3000, 1'b1, 1'b1);
  endtask

  task automatic t_wlat;
    // write and strobe in the same cycle: old contents apply
    cfg_we = 1'b1; cfg_iset = 1'b0; cfg_idx = 2'd3; cfg_lower = 1'b0;
    cfg_wdata = 32'h0;
    req_valid = 1'b1; req_ea = 32'h5000_4000; req_fetch = 1'b0;
    req_user = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    exp_hit("R10 same-cycle write unseen", 32'h7000_4000, 1'b1, 1'b1);
    look(32'h5000_4000, 1'b0, 1'b0);
    exp_miss("R10 write seen next cycle", 32'h5000_4000);
  endtask

  task automatic t_bypass;
    itrans_on = 1'b0;
    look(32'h9ABC_DEF0, 1'b1, 1'b1);
    exp_hit("R9 fetch bypass", 32'h9ABC_D000, 1'b1, 1'b1);
    chk_eq("R9 bypass flag", {31'b0, rsp_bypass}, 32'h1);
    chk_eq("R9 fault kept on bypass", fault_addr, 32'h5000_4000);
    look(32'h1234_5678, 1'b0, 1'b0);
    exp_miss("R9 data still translated", 32'h1234_5678);
    chk_eq("R9 no bypass flag", {31'b0, rsp_bypass}, 32'h0);
    itrans_on = 1'b1; dtrans_on = 1'b0;
    look(32'h0000_1FFF, 1'b1, 1'b0);
    exp_hit("R9 data-off bypasses fetch", 32'h0000_1000, 1'b1, 1'b1);
    chk_eq("R9 bypass flag 2", {31'b0, rsp_bypass}, 32'h1);
    dtrans_on = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_iset = 1'b0; cfg_idx = '0; cfg_lower = 1'b0;
    cfg_wdata = '0;
    req_valid = 1'b0; req_ea = '0; req_fetch = 1'b0; req_user = 1'b0;
    itrans_on = 1'b1; dtrans_on = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank();
    t_tag();
    t_priv();
    t_mask();
    t_prot();
    t_prio();
    t_wlat();
    t_bypass();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule